// File: doc/BRIEF.md
# Trap and Interrupt Entry Sequencer

This block carries out the entry into an exception or interrupt handler for a 16-bit processor that has a memory management unit. An entry request carries a vector address and a flag that marks it as an interrupt or a trap. It may also carry a replacement priority level. The request arrives on a valid/ready channel together with the processor's current status word, program counter and stack pointer.

Entry proceeds in fixed steps over a word-wide memory port that has a fault flag:
- the handler address is fetched from the vector word;
- the handler status word is fetched from the word after the vector;
- the old status word is pushed onto the kernel stack, then the old program counter.

The memory management status registers are told about the entry along the way.

A memory fault during entry abandons the attempt. The block then restarts the entry at the bus-error vector, keeping the state it captured on the first attempt. A fault during that retry is terminal: the block stops and raises a halt output until reset.

The request channel follows valid/ready rules. A request is taken on a cycle where both are high. `req_ready` is high only while the block is idle. A requester facing back-pressure must hold `req_valid` and all request fields steady until acceptance.

The memory port is a request/acknowledge pair. The block holds `mem_req`, address, write flag and write data steady until `mem_ack` arrives. `mem_fault` is meaningful only in an acknowledge cycle.

Top module: `trap_entry_seq`

## Requirements
- R1: While a vector word is being read (mem_req high, mem_we low), psw_o bits 15:14 are zero, so the read happens in kernel mode.
- R2: On success, pc_o equals the word read at the vector address. psw_o takes the word read at vector+2 ANDed with 16'hCFFF (bits 13:12 cleared), with the additions given in R3 and R4.
- R3: When req_ipl_en is 1, psw_o bits 7:5 become req_ipl. When it is 0, bits 7:5 keep the value from the vector word.
- R4: psw_o bits 13:12 receive bits 15:14 of the status word captured when the request was accepted.
- R5: The captured status word is written to address sp-2 first, and the captured PC is written to sp-4 second. Each push lowers the stack pointer by 2 before its write, so sp_o ends at sp-4.
- R6: Each entry attempt writes MMU status register 0 bit 12 through sr0_we/sr0_val: value 1 for a trap (req_is_irq=0) and value 0 for an interrupt.
- R7: Logging takes place when mmu_sr0 bits 15:13 are all zero and the vector is not 4. Logging is one sr2_we pulse carrying the vector, plus two sr1_we pulses whose sr1_data is 8'hF6 (bits 7:3 = -2 in 5-bit two's complement, bits 2:0 = register 6). In every other case no such pulses occur.
- R8: After a memory fault on the first attempt, the entry restarts with vector 4 (no logging). The status word and PC pushed are still those captured at acceptance, and sp restarts from the captured value.
- R9: A memory fault on the retry attempt ends in halt=1. In that state busy stays 1, done never pulses, req_ready stays 0 and psw_o shows the captured status word, until reset.
- R10: req_ready is 1 only when the block is idle. busy is 1 from acceptance until done. done is a single-cycle pulse.
- R11: Once mem_req is raised, it stays high with a stable address until mem_ack.
- R12: After reset: req_ready=1, busy=0, done=0, halt=0, mem_req=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Entry request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vector | input | 16 | Vector address |
| req_ipl_en | input | 1 | Replace priority level |
| req_ipl | input | 3 | Replacement priority level |
| req_is_irq | input | 1 | 1 = interrupt, 0 = trap |
| cur_psw | input | 16 | Current status word |
| cur_pc | input | 16 | Current program counter |
| cur_sp | input | 16 | Current kernel stack pointer |
| mmu_sr0 | input | 16 | MMU status register 0 contents |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 16 | Read data, valid with ack |
| mem_fault | input | 1 | Access faulted, valid with ack |
| sr0_we | output | 1 | Write MMU status register 0 bit 12 |
| sr0_val | output | 1 | Value for that bit |
| sr2_we | output | 1 | Write vector to MMU status register 2 |
| sr2_data | output | 16 | Value for status register 2 |
| sr1_we | output | 1 | Add one record to MMU status register 1 |
| sr1_data | output | 8 | Register-change record |
| pc_o | output | 16 | New program counter |
| psw_o | output | 16 | Working status word |
| sp_o | output | 16 | Working stack pointer |
| busy | output | 1 | Entry in progress or halted |
| done | output | 1 | Entry completed (pulse) |
| halt | output | 1 | Terminal double-fault state |

## Verification
Several properties are checked on every cycle:
- kernel-mode vector reads;
- steady memory requests until acknowledge;
- ready only when idle;
- single-cycle done;
- a stack pointer that drops by exactly 2 after each good push;
- a sticky halt;
- a logged vector never being the bus-error vector.

Only the bench scenarios can show that the fetched words end up in the new PC and status word with the correct mask, priority and previous-mode fields. The same holds for the push order on the stack, the exact number of logging pulses, and the retry and halt paths reached by injecting a fault at a chosen memory access.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOG_A, ST_LOG_B, ST_FETCH_PC,
    ST_FETCH_PSW, ST_PUSH_PSW, ST_PUSH_PC, ST_HALT
  } seq_state_t;

  localparam logic [15:0] KERNEL_MASK = 16'h3FFF;
  localparam logic [15:0] PREV_CLEAR  = 16'hCFFF;
  localparam logic [7:0]  SR1_SP_DEC2 = 8'hF6;
endpackage

// File: rtl/trap_psw_build.sv
module trap_psw_build #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] vec_word,
  input  logic          ipl_en,
  input  logic [2:0]    ipl,
  input  logic [DW-1:0] old_psw,
  output logic [DW-1:0] new_psw
);
  import trap_seq_pkg::*;
  always_comb begin
    new_psw = vec_word & PREV_CLEAR;
    if (ipl_en) new_psw[7:5] = ipl;
    new_psw[13:12] = old_psw[15:14];
  end
endmodule

// File: rtl/trap_log_gate.sv
module trap_log_gate #(
  parameter int DW = 16,
  parameter logic [DW-1:0] FAULT_VEC = 4
) (
  input  logic [DW-1:0] vector,
  input  logic [2:0]    sr0_top,
  output logic          log_en
);
  assign log_en = (sr0_top == 3'b000) && (vector != FAULT_VEC);
endmodule

// File: rtl/trap_attempt_ctr.sv
module trap_attempt_ctr #(
  parameter int MAX_TRIES = 3,
  localparam int CW = $clog2(MAX_TRIES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fault,
  output logic terminal
);
  logic [CW-1:0] tries;
  always_ff @(posedge clk) begin
    if (!rst_n)     tries <= '0;
    else if (start) tries <= CW'(1);
    else if (fault) tries <= tries + CW'(1);
  end
  assign terminal = (tries >= CW'(MAX_TRIES - 1));
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq #(
  parameter int DW = 16,
  parameter logic [DW-1:0] FAULT_VEC = 4,
  parameter int MAX_TRIES = 3,
  parameter int SP_STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [DW-1:0] req_vector,
  input  logic          req_ipl_en,
  input  logic [2:0]    req_ipl,
  input  logic          req_is_irq,
  input  logic [DW-1:0] cur_psw,
  input  logic [DW-1:0] cur_pc,
  input  logic [DW-1:0] cur_sp,
  input  logic [DW-1:0] mmu_sr0,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_fault,
  output logic          sr0_we,
  output logic          sr0_val,
  output logic          sr2_we,
  output logic [DW-1:0] sr2_data,
  output logic          sr1_we,
  output logic [7:0]    sr1_data,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] psw_o,
  output logic [DW-1:0] sp_o,
  output logic          busy,
  output logic          done,
  output logic          halt
);
  import trap_seq_pkg::*;

  localparam logic [DW-1:0] STEP = DW'(SP_STEP);
  localparam logic [DW-1:0] PSW_OFS = DW'(2);

  seq_state_t state;
  logic [DW-1:0] vec_q, old_psw, old_pc, old_sp, wpsw, wsp, npc;
  logic ipl_en_q, is_irq_q;
  logic [2:0] ipl_q;
  logic accept, log_en, fault_hit, terminal, mem_phase;
  logic [DW-1:0] built_psw;

  assign accept    = (state == ST_IDLE) && req_valid;
  assign mem_phase = (state == ST_FETCH_PC) || (state == ST_FETCH_PSW) ||
                     (state == ST_PUSH_PSW) || (state == ST_PUSH_PC);
  assign fault_hit = mem_phase && mem_ack && mem_fault;

  trap_log_gate #(.DW(DW), .FAULT_VEC(FAULT_VEC)) u_log (
    .vector(req_vector), .sr0_top(mmu_sr0[15:13]), .log_en(log_en));

  trap_attempt_ctr #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk(clk), .rst_n(rst_n), .start(accept), .fault(fault_hit),
    .terminal(terminal));

  trap_psw_build #(.DW(DW)) u_psw (
    .vec_word(mem_rdata), .ipl_en(ipl_en_q), .ipl(ipl_q),
    .old_psw(old_psw), .new_psw(built_psw));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      vec_q <= '0; old_psw <= '0; old_pc <= '0; old_sp <= '0;
      wpsw <= '0; wsp <= '0; npc <= '0;
      ipl_en_q <= 1'b0; ipl_q <= '0; is_irq_q <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (fault_hit) begin
        wsp <= old_sp;
        if (terminal) begin
          wpsw  <= old_psw;
          state <= ST_HALT;
        end else begin
          wpsw  <= old_psw & KERNEL_MASK;
          vec_q <= FAULT_VEC;
          state <= ST_FETCH_PC;
        end
      end else begin
        case (state)
          ST_IDLE: if (req_valid) begin
            vec_q    <= req_vector;
            ipl_en_q <= req_ipl_en;
            ipl_q    <= req_ipl;
            is_irq_q <= req_is_irq;
            old_psw  <= cur_psw;
            old_pc   <= cur_pc;
            old_sp   <= cur_sp;
            wsp      <= cur_sp;
            wpsw     <= cur_psw & KERNEL_MASK;
            state    <= log_en ? ST_LOG_A : ST_FETCH_PC;
          end
          ST_LOG_A: state <= ST_LOG_B;
          ST_LOG_B: state <= ST_FETCH_PC;
          ST_FETCH_PC: if (mem_ack) begin
            npc   <= mem_rdata;
            state <= ST_FETCH_PSW;
          end
          ST_FETCH_PSW: if (mem_ack) begin
            wpsw  <= built_psw;
            state <= ST_PUSH_PSW;
          end
          ST_PUSH_PSW: if (mem_ack) begin
            wsp   <= wsp - STEP;
            state <= ST_PUSH_PC;
          end
          ST_PUSH_PC: if (mem_ack) begin
            wsp   <= wsp - STEP;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
          default: state <= ST_HALT;
        endcase
      end
    end
  end

  always_comb begin
    mem_addr  = wsp - STEP;
    mem_wdata = '0;
    unique case (state)
      ST_FETCH_PC:  mem_addr = vec_q;
      ST_FETCH_PSW: mem_addr = vec_q + PSW_OFS;
      ST_PUSH_PSW:  mem_wdata = old_psw;
      ST_PUSH_PC:   mem_wdata = old_pc;
      default: ;
    endcase
  end

  assign mem_req   = mem_phase;
  assign mem_we    = (state == ST_PUSH_PSW) || (state == ST_PUSH_PC);
  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign halt      = (state == ST_HALT);
  assign sr0_we    = (state == ST_FETCH_PC) && mem_ack;
  assign sr0_val   = ~is_irq_q;
  assign sr2_we    = (state == ST_LOG_A);
  assign sr2_data  = vec_q;
  assign sr1_we    = (state == ST_LOG_A) || (state == ST_LOG_B);
  assign sr1_data  = SR1_SP_DEC2;
  assign pc_o      = npc;
  assign psw_o     = wpsw;
  assign sp_o      = wsp;
endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk #(
  parameter int DW = 16,
  parameter logic [DW-1:0] FAULT_VEC = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          busy,
  input logic          done,
  input logic          halt,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          mem_fault,
  input logic [DW-1:0] psw_o,
  input logic [DW-1:0] sp_o,
  input logic          sr2_we,
  input logic [DW-1:0] sr2_data
);
  AST_KERNEL_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (psw_o[15:14] == 2'b00)); // R1
  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack && !mem_fault) |=> (sp_o == $past(sp_o) - DW'(2))); // R5
  AST_NO_LOG_FAULT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    sr2_we |-> (sr2_data != FAULT_VEC)); // R7
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (halt && busy && !done)); // R9
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && busy)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R11
endmodule

bind trap_entry_seq trap_entry_seq_chk #(.DW(DW), .FAULT_VEC(FAULT_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy), .done(done),
  .halt(halt), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .mem_fault(mem_fault), .psw_o(psw_o), .sp_o(sp_o),
  .sr2_we(sr2_we), .sr2_data(sr2_data));

// File: tb/trap_entry_seq_tb.sv
module trap_entry_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_ready, req_ipl_en = 0, req_is_irq = 0;
  logic [15:0] req_vector = 0, cur_psw = 0, cur_pc = 0, cur_sp = 0, mmu_sr0 = 0;
  logic [2:0] req_ipl = 0;
  logic mem_req, mem_we, mem_ack = 0, mem_fault = 0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic sr0_we, sr0_val, sr2_we, sr1_we, busy, done, halt;
  logic [15:0] sr2_data, pc_o, psw_o, sp_o;
  logic [7:0] sr1_data;

  trap_entry_seq u_dut (.*);

  int checks = 0, fails = 0;
  logic [15:0] mem [0:255];
  logic [7:0] fmask = 0;
  int ack_idx = 0;
  int n_sr2 = 0, n_sr1 = 0, n_sr1_bad = 0, n_sr0 = 0, n_kbad = 0, n_rdybad = 0, n_hold_bad = 0;
  logic [15:0] last_sr2 = 0;
  logic last_sr0 = 0, prev_req = 0, prev_ack = 0;
  logic [15:0] prev_addr = 0;

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_fault <= fmask[ack_idx[2:0]];
      mem_rdata <= mem[mem_addr[8:1]];
      if (mem_we && !fmask[ack_idx[2:0]]) mem[mem_addr[8:1]] <= mem_wdata;
      ack_idx <= ack_idx + 1;
    end else begin
      mem_ack <= 1'b0; mem_fault <= 1'b0;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (sr2_we) begin n_sr2++; last_sr2 = sr2_data; end
    if (sr1_we) begin n_sr1++; if (sr1_data != 8'hF6) n_sr1_bad++; end
    if (sr0_we) begin n_sr0++; last_sr0 = sr0_val; end
    if (mem_req && !mem_we && psw_o[15:14] != 0) n_kbad++;
    if (req_ready && busy) n_rdybad++;
    if (prev_req && !prev_ack && (!mem_req || mem_addr != prev_addr)) n_hold_bad++;
    prev_req = mem_req; prev_ack = mem_ack; prev_addr = mem_addr;
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 313) ^ 16'h5A3C;
  endfunction

  task automatic preload();
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
  endtask

  typedef struct packed {
    logic [15:0] vec; logic ipl_en; logic [2:0] ipl; logic irq;
    logic [15:0] psw; logic [15:0] pc; logic [15:0] sp; logic [15:0] sr0;
    logic [7:0] fm;
  } case_t;

  localparam case_t TBL [7] = '{
    '{16'h0010, 1'b0, 3'd0, 1'b0, 16'hF0E4, 16'h1234, 16'h0100, 16'h0000, 8'h00},
    '{16'h0040, 1'b1, 3'd7, 1'b1, 16'h4000, 16'h2222, 16'h0180, 16'h0000, 8'h00},
    '{16'h0060, 1'b1, 3'd5, 1'b0, 16'h0000, 16'h0AAA, 16'h0120, 16'h8000, 8'h00},
    '{16'h0004, 1'b0, 3'd0, 1'b0, 16'hC000, 16'h0BBB, 16'h0140, 16'h0000, 8'h00},
    '{16'h0040, 1'b1, 3'd6, 1'b1, 16'hC011, 16'h3333, 16'h0160, 16'h0000, 8'h04},
    '{16'h00A8, 1'b0, 3'd0, 1'b0, 16'h8F00, 16'h4444, 16'h01A0, 16'h0000, 8'h01},
    '{16'h0030, 1'b1, 3'd2, 1'b0, 16'h40E0, 16'h5555, 16'h01C0, 16'h2000, 8'h08}
  };

  task automatic launch(input case_t c);
    preload();
    @(negedge clk);
    fmask = c.fm; ack_idx = 0;
    n_sr2 = 0; n_sr1 = 0; n_sr1_bad = 0; n_sr0 = 0; n_kbad = 0;
    req_vector = c.vec; req_ipl_en = c.ipl_en; req_ipl = c.ipl; req_is_irq = c.irq;
    cur_psw = c.psw; cur_pc = c.pc; cur_sp = c.sp; mmu_sr0 = c.sr0;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 200 && !done && !halt; k++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    preload();
    repeat (3) @(negedge clk);
    chk("R12 ready", req_ready, 1); chk("R12 busy", busy, 0);
    chk("R12 done", done, 0); chk("R12 halt", halt, 0); chk("R12 mem_req", mem_req, 0);
    rst_n = 1;
    @(negedge clk);

    for (int t = 0; t < 7; t++) begin
      case_t c = TBL[t];
      logic [15:0] ve, pw;
      logic lg;
      ve = (c.fm != 0) ? 16'h0004 : c.vec;
      lg = (c.sr0[15:13] == 0) && (c.vec != 16'h0004);
      launch(c);
      chk("R10 busy after accept", busy, 1);
      chk("R10 ready low when busy", req_ready, 0);
      wait_end();
      chk("R10 done", done, 1);
      pw = pat(ve[8:1] + 1) & 16'hCFFF;
      if (c.ipl_en) pw[7:5] = c.ipl;
      pw[13:12] = c.psw[15:14];
      chk($sformatf("R2 pc case %0d", t), pc_o, pat(ve[8:1]));
      chk($sformatf("R2 R3 R4 R8 psw case %0d", t), psw_o, pw);
      chk("R5 sp final", sp_o, c.sp - 16'd4);
      chk("R5 R8 pushed psw", mem[8'((c.sp - 16'd2) >> 1)], c.psw);
      chk("R5 R8 pushed pc", mem[8'((c.sp - 16'd4) >> 1)], c.pc);
      chk("R7 sr2 count", n_sr2, lg ? 1 : 0);
      chk("R7 sr1 count", n_sr1, lg ? 2 : 0);
      chk("R7 sr1 data", n_sr1_bad, 0);
      if (lg) chk("R7 sr2 value", last_sr2, c.vec);
      chk("R6 sr0 count", n_sr0, (c.fm != 0) ? 2 : 1);
      chk("R6 sr0 value", last_sr0, !c.irq);
      chk("R1 kernel fetch", n_kbad, 0);
      @(negedge clk);
      chk("R10 done single pulse", done, 0);
    end

    // R9: fault on the first attempt and on the retry
    begin
      case_t h = '{16'h0050, 1'b0, 3'd0, 1'b0, 16'hC3A0, 16'h7777, 16'h0100, 16'h0000, 8'h03};
      launch(h);
      wait_end();
      chk("R9 halt", halt, 1);
      chk("R9 no done", done, 0);
      repeat (5) @(negedge clk);
      chk("R9 halt sticky", halt, 1);
      chk("R9 busy", busy, 1);
      chk("R9 ready low", req_ready, 0);
      chk("R9 psw restored", psw_o, 16'hC3A0);
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R12 halt cleared", halt, 0);
      chk("R12 ready after reset", req_ready, 1);
    end

    chk("R10 ready never with busy", n_rdybad, 0);
    chk("R11 request held", n_hold_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule